// File: doc/BRIEF.md
# Presettable Synchronous 4-bit Counter

This block is a binary up-counter in which every change of state waits for the rising clock edge. A clear input forces the count to zero, a load input copies a 4-bit preset into the count, and two count enables must both be high for the count to advance. A carry output goes high when the count sits at its top value and the second enable is high, so a row of these counters can be chained, or one counter can be told when it is about to wrap.

The FEEDBACK parameter selects a second build. In it the inverted carry drives the load path inside the block. When the counter reaches its top value it reloads the preset on the data inputs instead of wrapping to zero, so the counter runs through 16 minus preset states. A preset of 6 gives a divide-by-10 stage and a preset of 14 gives a divide-by-2 stage, both on the same clock. The house reset input rst_n is separate from the functional clear input.

Top module: `pcnt_preset`

## Requirements
- R1: With rst_n low at a rising edge, the count q is 0 after that edge, whatever the other inputs.
- R2: With rst_n high and clr_n low at a rising edge, q is 0 after that edge, whatever ld_n, en_p, en_t and din hold.
- R3: With rst_n and clr_n high and ld_n low at a rising edge, q takes the value of din after that edge (din[0] goes to q[0]), even when en_p or en_t is low.
- R4: With rst_n, clr_n, ld_n, en_p and en_t all high at a rising edge, q rises by one after that edge, and 15 is followed by 0 when FEEDBACK is 0.
- R5: With rst_n, clr_n and ld_n high and en_p or en_t low at a rising edge, q keeps its value.
- R6: rco is high exactly when q is 15 and en_t is high. It follows q and en_t in the same cycle, with no register delay.
- R7: With FEEDBACK set to 1, a count step from 15 loads din instead of 0. With clr_n, ld_n, en_p and en_t held high, the count repeats every 16 minus din cycles, and rco pulses once per period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset to zero |
| clr_n | input | 1 | Synchronous active-low clear |
| ld_n | input | 1 | Synchronous active-low parallel load |
| en_p | input | 1 | Count enable that does not gate the carry |
| en_t | input | 1 | Count enable that also gates the carry |
| din | input | 4 | Preset value, bit 0 least significant |
| q | output | 4 | Current count |
| rco | output | 1 | Carry out: count at 15 and en_t high |

## Verification
The hardest case to reach from the ports is a conflict in which several controls are active at the same edge. Examples are a clear during a load, or a load while an enable is low. Random stimulus rarely lands the count at 15 just as such a conflict happens. Directed sequences first load 14 or 15 and then apply each conflict at that point. The random phase weights clear and load low so that long runs of counting still reach the wrap. A second instance built in feedback mode runs with presets 0, 6 and 14, and the bench measures the distance between its carry pulses.

// File: rtl/pcnt_pkg.sv
// Package: shared types for the presettable counter.
// Assumes nothing beyond IEEE 1800-2017 enums.
package pcnt_pkg;

    // Action the register takes on the next rising edge, decided by priority.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_INC   = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_CLEAR = 2'd3
    } pcnt_act_e;

endpackage

// File: rtl/pcnt_decode.sv
// Module: pcnt_decode
// Decides which action the count register takes on the next edge.
// Priority: reset, clear, load, count (both enables high), hold.
// Assumes all control inputs are synchronous to the counter clock.
module pcnt_decode
    import pcnt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr_n,
    input  logic      ld_n,
    input  logic      en_p,
    input  logic      en_t,
    output pcnt_act_e act
);

    // Priority decode of the control inputs.
    always_comb begin
        if (!rst_n || !clr_n) begin
            act = ACT_CLEAR;
        end else if (!ld_n) begin
            act = ACT_LOAD;
        end else if (en_p && en_t) begin
            act = ACT_INC;
        end else begin
            act = ACT_HOLD;
        end
    end

    // R3: a low enable never blocks a load
    a_r3_load_beats_enables : assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !ld_n) |-> (act == ACT_LOAD));

    // R5: a low enable with no clear or load holds the count
    a_r5_hold_when_disabled : assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && ld_n && !(en_p && en_t)) |-> (act == ACT_HOLD));

endmodule

// File: rtl/pcnt_reg.sv
// Module: pcnt_reg
// Count register that carries out the action chosen by pcnt_decode.
// Assumes a synchronous active-low reset and a single clock.
module pcnt_reg
    import pcnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pcnt_act_e        act,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);

    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    // Count state update on each rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            case (act)
                ACT_CLEAR: q <= '0;
                ACT_LOAD:  q <= din;
                ACT_INC:   q <= q + ONE;
                default:   q <= q;
            endcase
        end
    end

    // R1: reset clears the count
    a_r1_reset_zero : assert property (@(posedge clk)
        !rst_n |=> (q == '0));

    // R2: clear forces zero
    a_r2_clear_zero : assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_CLEAR) |=> (q == '0));

    // R3: load copies the preset
    a_r3_load_copies : assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_LOAD) |=> (q == $past(din)));

    // R4: increment advances by one, modulo 2**WIDTH
    a_r4_increment : assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_INC) |=> (q == $past(q) + ONE));

    // R5: hold keeps the count
    a_r5_hold_stable : assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_HOLD) |=> $stable(q));

endmodule

// File: rtl/pcnt_carry.sv
// Module: pcnt_carry
// Combinational carry: high when the count is at its maximum and en_t is high.
// Assumes q comes straight from the count register, with no added stage.
module pcnt_carry #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] q,
    input  logic             en_t,
    output logic             rco
);

    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    // Carry: AND of every count bit with the carry enable.
    always_comb begin
        rco = (&q) & en_t;
    end

    // R6: carry is never high while en_t is low
    a_r6_carry_needs_t : assert property (@(posedge clk) disable iff (!rst_n)
        rco |-> en_t);

    // R6: carry is only high at the top count
    a_r6_carry_at_top : assert property (@(posedge clk) disable iff (!rst_n)
        rco |-> (q == TOP));

endmodule

// File: rtl/pcnt_preset.sv
// Module: pcnt_preset (top)
// Presettable synchronous up-counter with clear, load, two enables and a carry.
// FEEDBACK=1 drives load from the inverted carry inside the block, so the
// counter reloads din after its top value and runs modulo (2**WIDTH - din).
// Assumes every input is synchronous to clk.
module pcnt_preset
    import pcnt_pkg::*;
#(
    parameter int WIDTH    = 4,
    parameter bit FEEDBACK = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_n,
    input  logic             ld_n,
    input  logic             en_p,
    input  logic             en_t,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q,
    output logic             rco
);

    pcnt_act_e act;
    logic      ld_eff_n;

    // Load path: the external load alone, or combined with the inverted carry.
    generate
        if (FEEDBACK) begin : g_fb
            always_comb begin
                ld_eff_n = ld_n & ~rco;
            end

            // R7: a step from the top count loads the preset
            a_r7_reload_preset : assert property (@(posedge clk) disable iff (!rst_n)
                (rco && clr_n) |=> (q == $past(din)));
        end else begin : g_plain
            always_comb begin
                ld_eff_n = ld_n;
            end

            // R4: the count wraps from the top value to zero
            a_r4_wrap_zero : assert property (@(posedge clk) disable iff (!rst_n)
                (rco && clr_n && ld_n && en_p) |=> (q == '0));
        end
    endgenerate

    pcnt_decode u_decode (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_n (clr_n),
        .ld_n  (ld_eff_n),
        .en_p  (en_p),
        .en_t  (en_t),
        .act   (act)
    );

    pcnt_reg #(.WIDTH(WIDTH)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .act   (act),
        .din   (din),
        .q     (q)
    );

    pcnt_carry #(.WIDTH(WIDTH)) u_carry (
        .clk   (clk),
        .rst_n (rst_n),
        .q     (q),
        .en_t  (en_t),
        .rco   (rco)
    );

endmodule

// File: tb/pcnt_preset_tb.sv
module pcnt_preset_tb;

    logic       clk = 1'b0;
    logic       rst_n, clr_n, ld_n, en_p, en_t;
    logic [3:0] din, q;
    logic       rco;
    logic       f_rst_n;
    logic [3:0] f_din, f_q;
    logic       f_rco;

    int n_run = 0;
    int n_fail = 0;
    logic [3:0] exp_q, exp_f;
    int cyc = 0;

    always #4 clk = ~clk;

    pcnt_preset #(.WIDTH(4), .FEEDBACK(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .ld_n(ld_n),
        .en_p(en_p), .en_t(en_t), .din(din), .q(q), .rco(rco));

    pcnt_preset #(.WIDTH(4), .FEEDBACK(1'b1)) u_dut_fb (
        .clk(clk), .rst_n(f_rst_n), .clr_n(1'b1), .ld_n(1'b1),
        .en_p(1'b1), .en_t(1'b1), .din(f_din), .q(f_q), .rco(f_rco));

    // Reference next state for the plain counter (R1..R5).
    function automatic logic [3:0] nxt(input logic r, c, l, p, t,
                                       input logic [3:0] d, cur);
        if (!r || !c) return 4'd0;
        if (!l) return d;
        if (p && t) return cur + 4'd1;
        return cur;
    endfunction

    // Reference next state for the feedback counter (R7).
    function automatic logic [3:0] nxt_fb(input logic r, input logic [3:0] d, cur);
        if (!r) return 4'd0;
        if (cur == 4'd15) return d;
        return cur + 4'd1;
    endfunction

    task automatic chk(input string tag, input int act, input int expv);
        n_run++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // One edge: update both models, then sample away from the edge.
    task automatic tick(input string tag);
        @(posedge clk);
        exp_q = nxt(rst_n, clr_n, ld_n, en_p, en_t, din, exp_q);
        exp_f = nxt_fb(f_rst_n, f_din, exp_f);
        #2;
        chk(tag, q, exp_q);
        chk("R6 carry", rco, ((exp_q == 4'd15) && en_t));
        chk("R7 feedback count", f_q, exp_f);
    endtask

    task automatic drive(input logic c, l, p, t, input logic [3:0] d);
        clr_n = c; ld_n = l; en_p = p; en_t = t; din = d;
    endtask

    // Measure the feedback period for one preset (R7).
    task automatic period(input logic [3:0] pre);
        int gap;
        f_din = pre;
        while (!(f_rco)) tick("R7 seek");
        gap = 0;
        do begin
            tick("R7 run");
            gap++;
        end while (!f_rco);
        chk("R7 period", gap, 16 - pre);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        exp_q = 4'd0; exp_f = 4'd0;
        rst_n = 1'b0; f_rst_n = 1'b0; f_din = 4'd0;
        drive(1'b1, 1'b0, 1'b1, 1'b1, 4'd9);
        tick("R1 reset");
        tick("R1 reset");
        chk("R1 reset carry", rco, 0);
        rst_n = 1'b1; f_rst_n = 1'b1;

        // R3: load 14 with both enables low, then count to 15 and wrap (R4).
        drive(1'b1, 1'b0, 1'b0, 1'b0, 4'd14); tick("R3 load no enable");
        drive(1'b1, 1'b1, 1'b1, 1'b1, 4'd0);  tick("R4 count to top");
        chk("R6 carry at top", rco, 1);
        drive(1'b1, 1'b1, 1'b1, 1'b0, 4'd0);
        #1 chk("R6 carry gated by T", rco, 0);
        tick("R5 hold T low");
        drive(1'b1, 1'b1, 1'b0, 1'b1, 4'd0);  tick("R5 hold P low");
        chk("R6 carry with P low", rco, 1);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 4'd0);  tick("R4 wrap to zero");
        // R2: clear beats a load at the top.
        drive(1'b1, 1'b0, 1'b1, 1'b1, 4'd15); tick("R3 load 15");
        drive(1'b0, 1'b0, 1'b1, 1'b1, 4'd7);  tick("R2 clear over load");
        drive(1'b1, 1'b0, 1'b1, 1'b1, 4'd5);  tick("R3 load 5");
        drive(1'b0, 1'b1, 1'b0, 1'b0, 4'd5);  tick("R2 clear no enable");
        rst_n = 1'b0; drive(1'b1, 1'b0, 1'b1, 1'b1, 4'd3); tick("R1 reset over load");
        rst_n = 1'b1;

        // Random phase, biased toward counting.
        for (int i = 0; i < 600; i++) begin
            drive(($urandom % 16) != 0, ($urandom % 10) != 0,
                  ($urandom % 4) != 0, ($urandom % 4) != 0, 4'($urandom));
            tick("R2-R5 random");
        end

        // Feedback instance periods for three presets.
        drive(1'b1, 1'b1, 1'b1, 1'b1, 4'd0);
        period(4'd0);
        period(4'd6);
        period(4'd14);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule